// File: doc/BRIEF.md
# Synchronous Shift Serial Port

This block is a half-duplex, eight-bit synchronous serial port of the kind found as a shift-register mode in small controllers. One bidirectional data line carries the bits in either direction, and a second line carries a shift clock that the port generates itself. All timing runs from an oscillator-rate clock enable (`osc_en`). Each bit occupies a cell of twelve enabled ticks. Inside each cell the data moves and the clock edges fall at fixed phases.

Software starts a transmission by writing a byte to the buffer while the port is idle. It starts a reception by clearing the receive flag while reception is enabled. Each direction has its own completion flag. A flag sets when the eighth cell ends and stays set until software clears it. The received byte is held on `rx_data_o` until the next reception completes.

Top module: `sync_shift_port`

## Requirements
- R1: After reset `sclk_o` is 1, `sd_o` is 1, `sd_oe` is 0, both completion flags are 0 and `rx_data_o` is 0.
- R2: A `buf_wr` pulse while idle starts a transmission. The byte appears on `sd_o` least significant bit first, each bit for one cell of 12 enabled ticks. `sd_oe` is 1 for the whole 96-tick transfer. Afterwards `sd_o` returns to 1 and `sd_oe` returns to 0.
- R3: Inside an active cell, with phases numbered 0 to 11 from the cell start, `sclk_o` is 0 for phases 4 to 9 and 1 otherwise. It rises at phase 10 and is 1 whenever the port is idle. A transmitted bit changes only at phase 0, so it is valid 10 ticks before the rising edge and held for 2 ticks after it.
- R4: A clock cycle with `osc_en` at 0 advances neither the phase nor the bit position, and changes no output.
- R5: `tx_done_o` sets at the end of the eighth transmit cell. It stays set until a `txf_clr` pulse.
- R6: A `rxf_clr` pulse while `rx_enable` is 1 and the port is idle clears `rx_done_o` and starts an eight-cell reception with `sd_oe` at 0. `rx_done_o` sets at the end of the eighth cell.
- R7: During a reception, `sd_i` is sampled on the enabled tick that moves phase 9 to phase 10, which is the shift-clock rising edge. The first sample becomes bit 0. When the reception completes, `rx_data_o` shows the byte, and it does not change otherwise.
- R8: While a transfer is active, `buf_wr` and reception starts are ignored. The running transfer continues unchanged.
- R9: `rxf_clr` with `rx_enable` at 0 only clears `rx_done_o` and starts no transfer.
- R10: When `buf_wr` and a valid reception start arrive in the same idle cycle, the transmission wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate tick enable |
| buf_wr | input | 1 | Buffer write pulse, starts transmit |
| buf_wdata | input | DATA_W | Byte to transmit |
| rx_enable | input | 1 | Reception permitted |
| txf_clr | input | 1 | Clear transmit-done flag |
| rxf_clr | input | 1 | Clear receive-done flag, may start reception |
| sd_i | input | 1 | Serial data from the pin |
| sd_o | output | 1 | Serial data to the pin |
| sd_oe | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock output |
| tx_done_o | output | 1 | Transmit complete flag |
| rx_done_o | output | 1 | Receive complete flag |
| rx_data_o | output | DATA_W | Last received byte |

## Verification
The bench builds the port with its default parameters: an 8-bit word, a 12-tick cell, and the clock falling at phase 4 and rising at phase 10. It drives `osc_en` every cycle, every second cycle and every third cycle, so frozen ticks land at every phase of a cell. During a reception, `sd_i` carries the intended bit only while the phase is 9 and carries its inverse at every other phase. A sample taken one tick early or late therefore corrupts the received byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef struct packed {
        logic active;
        logic rx_mode;
        logic tx_flag;
        logic rx_flag;
    } ssp_ctl_t;
endpackage

// File: rtl/ssp_cell_timer.sv
module ssp_cell_timer #(
    parameter int CELL_TICKS = 12,
    parameter int FALL_PHASE = 4,
    parameter int RISE_PHASE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic start,
    output logic sample_stb,
    output logic cell_end_stb,
    output logic sclk_low
);
    localparam int PH_W = $clog2(CELL_TICKS);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CELL_TICKS - 1);
    localparam logic [PH_W-1:0] SMP_PH  = PH_W'(RISE_PHASE - 1);
    localparam logic [PH_W-1:0] FALL_PH = PH_W'(FALL_PHASE);
    localparam logic [PH_W-1:0] RISE_PH = PH_W'(RISE_PHASE);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (start)
            phase_d = '0;
        else if (run && tick)
            phase_d = (phase_q == LAST_PH) ? '0 : phase_q + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign sample_stb   = run && tick && (phase_q == SMP_PH);
    assign cell_end_stb = run && tick && (phase_q == LAST_PH);
    assign sclk_low     = run && (phase_q >= FALL_PH) && (phase_q < RISE_PH);

    // R3
    phase_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST_PH);
    // R4
    frozen_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !start) |=> $stable(phase_q));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              arm,
    input  logic              rx_mode,
    input  logic              din,
    input  logic              sample_stb,
    input  logic              cell_end_stb,
    output logic              dout,
    output logic [DATA_W-1:0] word,
    output logic              last_cell
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg_d, shreg_q;
    logic [CNT_W-1:0]  cnt_d, cnt_q;

    always_comb begin
        shreg_d = shreg_q;
        cnt_d   = cnt_q;
        if (load)
            shreg_d = load_data;
        else if (rx_mode && sample_stb)
            shreg_d = {din, shreg_q[DATA_W-1:1]};
        else if (!rx_mode && cell_end_stb)
            shreg_d = {1'b1, shreg_q[DATA_W-1:1]};
        if (arm)
            cnt_d = '0;
        else if (cell_end_stb)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '1;
            cnt_q   <= '0;
        end else begin
            shreg_q <= shreg_d;
            cnt_q   <= cnt_d;
        end
    end

    assign dout      = shreg_q[0];
    assign word      = shreg_q;
    assign last_cell = cell_end_stb && (cnt_q == LAST_BIT);

    // R2
    count_cleared_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (cnt_q == '0));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
    parameter int DATA_W     = 8,
    parameter int CELL_TICKS = 12,
    parameter int FALL_PHASE = 4,
    parameter int RISE_PHASE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              rx_enable,
    input  logic              txf_clr,
    input  logic              rxf_clr,
    input  logic              sd_i,
    output logic              sd_o,
    output logic              sd_oe,
    output logic              sclk_o,
    output logic              tx_done_o,
    output logic              rx_done_o,
    output logic [DATA_W-1:0] rx_data_o
);
    import ssp_pkg::*;

    ssp_ctl_t          st_d, st_q;
    logic [DATA_W-1:0] rx_byte_d, rx_byte_q;
    logic              start_tx, start_rx;
    logic              sample_stb, cell_end_stb, sclk_low;
    logic              dout, last_cell;
    logic [DATA_W-1:0] word;

    assign start_tx = buf_wr && !st_q.active;
    assign start_rx = rxf_clr && rx_enable && !st_q.active && !buf_wr;

    ssp_cell_timer #(
        .CELL_TICKS(CELL_TICKS),
        .FALL_PHASE(FALL_PHASE),
        .RISE_PHASE(RISE_PHASE)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (osc_en),
        .run         (st_q.active),
        .start       (start_tx || start_rx),
        .sample_stb  (sample_stb),
        .cell_end_stb(cell_end_stb),
        .sclk_low    (sclk_low)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start_tx),
        .load_data   (buf_wdata),
        .arm         (start_tx || start_rx),
        .rx_mode     (st_q.rx_mode),
        .din         (sd_i),
        .sample_stb  (sample_stb),
        .cell_end_stb(cell_end_stb),
        .dout        (dout),
        .word        (word),
        .last_cell   (last_cell)
    );

    always_comb begin
        st_d      = st_q;
        rx_byte_d = rx_byte_q;
        if (txf_clr) st_d.tx_flag = 1'b0;
        if (rxf_clr) st_d.rx_flag = 1'b0;
        if (start_tx) begin
            st_d.active  = 1'b1;
            st_d.rx_mode = 1'b0;
        end else if (start_rx) begin
            st_d.active  = 1'b1;
            st_d.rx_mode = 1'b1;
        end else if (last_cell) begin
            st_d.active = 1'b0;
            if (st_q.rx_mode) begin
                st_d.rx_flag = 1'b1;
                rx_byte_d    = word;
            end else begin
                st_d.tx_flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            rx_byte_q <= '0;
        end else begin
            st_q      <= st_d;
            rx_byte_q <= rx_byte_d;
        end
    end

    assign sd_oe     = st_q.active && !st_q.rx_mode;
    assign sd_o      = sd_oe ? dout : 1'b1;
    assign sclk_o    = !sclk_low;
    assign tx_done_o = st_q.tx_flag;
    assign rx_done_o = st_q.rx_flag;
    assign rx_data_o = rx_byte_q;

    // R3
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> sclk_o);
    // R5
    tx_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_o) |-> $past(st_q.active && !st_q.rx_mode));
    // R6
    rx_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done_o) |-> $past(st_q.active && st_q.rx_mode));
    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !last_cell && (buf_wr || rxf_clr))
            |=> (st_q.active && $stable(st_q.rx_mode)));
    // R9
    no_rx_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_clr && !rx_enable && !buf_wr && !st_q.active) |=> !st_q.active);
endmodule

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic       rx_enable = 1'b0;
    logic       txf_clr = 1'b0;
    logic       rxf_clr = 1'b0;
    logic       sd_i = 1'b0;
    logic       sd_o, sd_oe, sclk_o, tx_done_o, rx_done_o;
    logic [7:0] rx_data_o;

    always #2.5 clk = ~clk;

    sync_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .rx_enable(rx_enable), .txf_clr(txf_clr),
        .rxf_clr(rxf_clr), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
        .sclk_o(sclk_o), .tx_done_o(tx_done_o), .rx_done_o(rx_done_o),
        .rx_data_o(rx_data_o)
    );

    // behavioural reference
    int         m_act = 0, m_rx = 0, m_ph = 0, m_bit = 0, m_txf = 0, m_rxf = 0;
    logic [7:0] m_byte = 8'h00, m_acc = 8'h00, m_rxd = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_rx = 0; m_ph = 0; m_bit = 0;
            m_txf = 0; m_rxf = 0; m_rxd = 8'h00;
        end else begin
            int go_tx, go_rx;
            go_tx = (buf_wr && m_act == 0) ? 1 : 0;
            go_rx = (rxf_clr && rx_enable && m_act == 0 && !buf_wr) ? 1 : 0;
            if (txf_clr) m_txf = 0;
            if (rxf_clr) m_rxf = 0;
            if (go_tx == 1) begin
                m_act = 1; m_rx = 0; m_byte = buf_wdata; m_ph = 0; m_bit = 0;
            end else if (go_rx == 1) begin
                m_act = 1; m_rx = 1; m_ph = 0; m_bit = 0; m_acc = 8'h00;
            end else if (m_act == 1 && osc_en) begin
                if (m_rx == 1 && m_ph == 9) m_acc[m_bit] = sd_i;
                if (m_ph == 11) begin
                    m_ph = 0;
                    if (m_bit == 7) begin
                        m_act = 0;
                        if (m_rx == 1) begin m_rxf = 1; m_rxd = m_acc; end
                        else m_txf = 1;
                    end else m_bit++;
                end else m_ph++;
            end
        end
    end

    int vectors = 0, miscompares = 0, cyc_n = 0, osc_div = 1;
    logic [7:0] rx_pat = 8'h00;

    task automatic fld(input string tag, input string name, input int act, input int exp,
                       inout int bad);
        if (act != exp) begin
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, name, act, exp, cyc_n);
            bad = 1;
        end
    endtask

    task automatic check(input string tag);
        int bad = 0;
        int e_oe, e_sclk, e_sd;
        e_oe   = (m_act == 1 && m_rx == 0) ? 1 : 0;
        e_sclk = (m_act == 1 && m_ph >= 4 && m_ph <= 9) ? 0 : 1;
        e_sd   = (e_oe == 1) ? int'(m_byte[m_bit]) : 1;
        vectors++;
        fld({tag, "/R3"}, "sclk_o", int'(sclk_o), e_sclk, bad);
        fld({tag, "/R2"}, "sd_oe", int'(sd_oe), e_oe, bad);
        fld({tag, "/R2"}, "sd_o", int'(sd_o), e_sd, bad);
        fld({tag, "/R5"}, "tx_done_o", int'(tx_done_o), m_txf, bad);
        fld({tag, "/R6"}, "rx_done_o", int'(rx_done_o), m_rxf, bad);
        fld({tag, "/R7"}, "rx_data_o", int'(rx_data_o), int'(m_rxd), bad);
        if (bad != 0) miscompares++;
    endtask

    task automatic run_cyc(input string tag);
        @(negedge clk);
        check(tag);
        cyc_n++;
        osc_en = (osc_div <= 1) || (cyc_n % osc_div == 0);
        if (m_act == 1 && m_rx == 1)
            sd_i = (m_ph == 9) ? rx_pat[m_bit] : ~rx_pat[m_bit];
        else
            sd_i = 1'b0;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) run_cyc(tag);
    endtask

    task automatic finish_xfer(input string tag);
        int guard = 0;
        while (m_act == 1 && guard < 3000) begin run_cyc(tag); guard++; end
        if (m_act == 1) begin
            $display("FAIL %s transfer never completed actual=busy expected=idle", tag);
            miscompares++;
        end
        idle(tag, 3);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            $display("FAIL watchdog actual=%0d cycles expected=completion", wd);
            miscompares++;
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        run_cyc("R1");
        idle("R1", 4);

        // R2, R3: transmit 0xA5 at full tick rate, busy write mid-way (R8)
        osc_div = 1;
        buf_wdata = 8'hA5; buf_wr = 1'b1; run_cyc("R2"); buf_wr = 1'b0;
        idle("R3", 30);
        buf_wdata = 8'h3C; buf_wr = 1'b1; rx_enable = 1'b1; rxf_clr = 1'b1;
        run_cyc("R8"); buf_wr = 1'b0; rxf_clr = 1'b0; rx_enable = 1'b0;
        finish_xfer("R2");
        idle("R5", 5);
        txf_clr = 1'b1; run_cyc("R5"); txf_clr = 1'b0;
        idle("R5", 3);

        // R4: transmit 0x01 with a tick every third clock
        osc_div = 3;
        buf_wdata = 8'h01; buf_wr = 1'b1; run_cyc("R4"); buf_wr = 1'b0;
        finish_xfer("R4");
        txf_clr = 1'b1; run_cyc("R5"); txf_clr = 1'b0;

        // R6, R7: receive 0x6B with a tick every second clock, busy write (R8)
        osc_div = 2; rx_pat = 8'h6B; rx_enable = 1'b1;
        rxf_clr = 1'b1; run_cyc("R6"); rxf_clr = 1'b0;
        idle("R7", 50);
        buf_wdata = 8'hC3; buf_wr = 1'b1; run_cyc("R8"); buf_wr = 1'b0;
        finish_xfer("R7");

        // R9: clear without enable starts nothing
        rx_enable = 1'b0;
        rxf_clr = 1'b1; run_cyc("R9"); rxf_clr = 1'b0;
        idle("R9", 20);

        // R10: simultaneous write and reception start
        osc_div = 1; rx_enable = 1'b1;
        buf_wdata = 8'hF0; buf_wr = 1'b1; rxf_clr = 1'b1;
        run_cyc("R10"); buf_wr = 1'b0; rxf_clr = 1'b0;
        finish_xfer("R10");

        // R7: receive 0x80 at full tick rate
        rx_pat = 8'h80;
        rxf_clr = 1'b1; run_cyc("R6"); rxf_clr = 1'b0;
        finish_xfer("R7");
        idle("R7", 10);

        summary();
    end
endmodule